// File: doc/BRIEF.md
# Dispatch Group Formation Checker

This block keeps track of one dispatch group while it is being built. A group holds up to five slots of instructions. A scheduler offers a candidate instruction as a class code. A combinational query then answers with one of three verdicts: the instruction may join the group, the group must be closed first, or a filler no-op must be placed first. When the scheduler places an instruction or a filler, it pulses one of two strobes. The block then updates its per-group unit counters, single-use flags, slot count and count-register flag.

Opcode decoding is done elsewhere. Only the class code reaches this block. Memory address overlap is also judged outside the block and arrives as one hazard bit that goes with the query. A second query bit marks a branch that goes through the count register. A commit bit marks an instruction that writes the count register.

Top module: `dispatch_group_chk`

## Requirements
- R1: Class codes are 0 pseudo, 1 integer, 2 integer-must-lead, 3 load, 4 store, 5 floating point, 6 condition register, 7 special register, 8 vector ALU, 9 vector permute and 10 branch. Codes 11 to 15 act as pseudo. Verdict codes are 0 no hazard, 1 close group and 2 insert filler. After reset the group is empty, and a query of any class answers 0.
- R2: At most two integer-class instructions (codes 1 and 2 together) fit in a group. A third integer query answers 1. A full integer quota does not block loads, stores or floating point.
- R3: At most two load/store instructions (codes 3 and 4 together) fit in a group, and at most two floating-point instructions. The next query of that unit answers 1.
- R4: Vector ALU and vector permute each fit once per group. A second query of the same class answers 1, while the other class is still accepted.
- R5: Condition-register, special-register and integer-must-lead instructions are accepted only when the group is empty. In any later slot their query answers 1.
- R6: Only a branch may take the fifth slot. When four slots are used, every non-branch query answers 1 and a branch query answers 0. A branch query never answers 1.
- R7: Committing a branch closes the group at once. The next group starts empty.
- R8: After a special-register commit that writes the count register, a query for a branch through the count register answers 2 until the group ends. A plain branch query still answers 0.
- R9: The external overlap bit makes a load query answer 2. It has no effect on other classes. Quota and slot-position hazards (answer 1) take priority over it.
- R10: Each filler strobe advances the slot count by one. The fifth used slot empties the group and clears all counters and flags.
- R11: A pseudo query always answers 0, whatever the query bits are. A pseudo commit changes no state.
- R12: If the commit and filler strobes arrive in the same cycle, both are ignored, and the error output is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| qry_class | input | 4 | Class code of the candidate instruction |
| qry_ctr_branch | input | 1 | Candidate is a branch through the count register |
| qry_overlap | input | 1 | External load-after-store overlap hazard for the candidate |
| qry_verdict | output | 2 | 0 no hazard, 1 close group, 2 insert filler |
| cmt_vld | input | 1 | Commit the instruction on cmt_class |
| cmt_class | input | 4 | Class code of the committed instruction |
| cmt_sets_ctr | input | 1 | Committed special-register instruction writes the count register |
| noop_vld | input | 1 | Commit a filler no-op |
| strobe_err | output | 1 | High one cycle after both strobes were asserted together |

## Verification
Two groups of functions can meet in one cycle. One is the two update paths, instruction commit and filler commit. The other is two hazard rules on the same query: a resource or slot rule together with a filler rule. The bench asserts both strobes in one clock. It checks that the error output rises on the next cycle and that a lead-only query is still accepted, which shows the slot count did not move. For the hazard rules, it presents a load with the overlap bit after the load/store quota is full, and it expects the close verdict to win over the filler verdict.

// File: rtl/dg_pkg.sv
package dg_pkg;

  typedef enum logic [3:0] {
    CL_PSEUDO  = 4'd0,
    CL_INT     = 4'd1,
    CL_INTLEAD = 4'd2,
    CL_LOAD    = 4'd3,
    CL_STORE   = 4'd4,
    CL_FP      = 4'd5,
    CL_CR      = 4'd6,
    CL_SPR     = 4'd7,
    CL_VALU    = 4'd8,
    CL_VPERM   = 4'd9,
    CL_BRANCH  = 4'd10
  } dg_class_e;

  typedef enum logic [1:0] {
    VD_NONE  = 2'd0,
    VD_CLOSE = 2'd1,
    VD_FILL  = 2'd2
  } dg_verdict_e;

  localparam int NUM_UNITS = 7;

  // unit index per class; NUM_UNITS means "no unit"
  function automatic int unit_of(logic [3:0] c);
    case (c)
      CL_INT, CL_INTLEAD: return 0;
      CL_LOAD, CL_STORE:  return 1;
      CL_FP:              return 2;
      CL_CR:              return 3;
      CL_SPR:             return 4;
      CL_VALU:            return 5;
      CL_VPERM:           return 6;
      default:            return NUM_UNITS;
    endcase
  endfunction

  function automatic logic is_real(logic [3:0] c);
    return (c >= 4'd1) && (c <= 4'd10);
  endfunction

  function automatic logic is_lead_only(logic [3:0] c);
    return (c == CL_CR) || (c == CL_SPR) || (c == CL_INTLEAD);
  endfunction

endpackage

// File: rtl/dg_rst_sync.sv
module dg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dg_query.sv
module dg_query
  import dg_pkg::*;
#(
  parameter int SLOT_W    = 3,
  parameter int LAST_SLOT = 4
) (
  input  logic [3:0]           cls,
  input  logic                 ctr_branch,
  input  logic                 overlap,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [NUM_UNITS-1:0] unit_full,
  input  logic                 ctr_flag,
  output logic [1:0]           verdict
);

  logic quota_hit;
  logic lead_hit;
  logic last_hit;
  logic ctr_hit;
  logic ovl_hit;
  int   uidx;

  always_comb begin
    uidx      = unit_of(cls);
    quota_hit = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (uidx == u && unit_full[u]) quota_hit = 1'b1;
    end
    lead_hit = is_lead_only(cls) && (slot != '0);
    last_hit = (slot == SLOT_W'(LAST_SLOT)) && (cls != CL_BRANCH);
    ctr_hit  = ctr_flag && ctr_branch && (cls == CL_BRANCH);
    ovl_hit  = overlap && (cls == CL_LOAD);

    if (!is_real(cls))               verdict = VD_NONE;
    else if (quota_hit)              verdict = VD_CLOSE;
    else if (lead_hit || last_hit)   verdict = VD_CLOSE;
    else if (ctr_hit)                verdict = VD_FILL;
    else if (ovl_hit)                verdict = VD_FILL;
    else                             verdict = VD_NONE;
  end

endmodule

// File: rtl/dg_state.sv
module dg_state
  import dg_pkg::*;
#(
  parameter int MAX_SLOTS = 5,
  parameter int INT_QUOTA = 2,
  parameter int LS_QUOTA  = 2,
  parameter int FP_QUOTA  = 2,
  localparam int SLOT_W   = $clog2(MAX_SLOTS),
  localparam int MAXQ_A   = (INT_QUOTA > LS_QUOTA) ? INT_QUOTA : LS_QUOTA,
  localparam int MAXQ     = (MAXQ_A > FP_QUOTA) ? MAXQ_A : FP_QUOTA,
  localparam int CNT_W    = $clog2(MAXQ + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmt_vld,
  input  logic [3:0]           cmt_class,
  input  logic                 cmt_sets_ctr,
  input  logic                 noop_vld,
  output logic [SLOT_W-1:0]    slot,
  output logic [NUM_UNITS-1:0] unit_full,
  output logic                 ctr_flag,
  output logic                 strobe_err
);

  localparam int LAST_SLOT = MAX_SLOTS - 1;

  logic              cmt_ok;
  logic              noop_ok;
  logic              step;
  logic              close_grp;
  logic              slot_en;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              ctr_q, ctr_d;
  logic              err_q, err_d;
  int                cmt_unit;

  always_comb begin
    cmt_ok    = cmt_vld && !noop_vld && is_real(cmt_class);
    noop_ok   = noop_vld && !cmt_vld;
    step      = cmt_ok || noop_ok;
    close_grp = (cmt_ok && (cmt_class == CL_BRANCH)) ||
                (step && (slot_q == SLOT_W'(LAST_SLOT)));
    cmt_unit  = unit_of(cmt_class);
    err_d     = cmt_vld && noop_vld;
    slot_en   = step;
    slot_d    = slot_q;
    ctr_d     = ctr_q;
    if (close_grp) begin
      slot_d = '0;
      ctr_d  = 1'b0;
    end else if (step) begin
      slot_d = slot_q + 1'b1;
      if (cmt_ok && (cmt_class == CL_SPR) && cmt_sets_ctr) ctr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      ctr_q  <= 1'b0;
    end else if (slot_en) begin
      slot_q <= slot_d;
      ctr_q  <= ctr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    localparam int QG = (g == 0) ? INT_QUOTA :
                        (g == 1) ? LS_QUOTA  :
                        (g == 2) ? FP_QUOTA  : 1;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_en;
    logic             hit;

    always_comb begin
      hit    = cmt_ok && (cmt_unit == g);
      cnt_en = close_grp || hit;
      cnt_d  = cnt_q;
      if (close_grp)                     cnt_d = '0;
      else if (cnt_q < CNT_W'(QG))       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign unit_full[g] = (cnt_q >= CNT_W'(QG));
  end

  assign slot       = slot_q;
  assign ctr_flag   = ctr_q;
  assign strobe_err = err_q;

endmodule

// File: rtl/dispatch_group_chk.sv
module dispatch_group_chk
  import dg_pkg::*;
#(
  parameter int MAX_SLOTS = 5,
  parameter int INT_QUOTA = 2,
  parameter int LS_QUOTA  = 2,
  parameter int FP_QUOTA  = 2,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] qry_class,
  input  logic       qry_ctr_branch,
  input  logic       qry_overlap,
  output logic [1:0] qry_verdict,
  input  logic       cmt_vld,
  input  logic [3:0] cmt_class,
  input  logic       cmt_sets_ctr,
  input  logic       noop_vld,
  output logic       strobe_err
);

  logic                 grp_rst_n;
  logic [SLOT_W-1:0]    slot_cnt;
  logic [NUM_UNITS-1:0] unit_full;
  logic                 ctr_flag;

  dg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (grp_rst_n)
  );

  dg_state #(
    .MAX_SLOTS (MAX_SLOTS),
    .INT_QUOTA (INT_QUOTA),
    .LS_QUOTA  (LS_QUOTA),
    .FP_QUOTA  (FP_QUOTA)
  ) u_state (
    .clk          (clk),
    .rst_n        (grp_rst_n),
    .cmt_vld      (cmt_vld),
    .cmt_class    (cmt_class),
    .cmt_sets_ctr (cmt_sets_ctr),
    .noop_vld     (noop_vld),
    .slot         (slot_cnt),
    .unit_full    (unit_full),
    .ctr_flag     (ctr_flag),
    .strobe_err   (strobe_err)
  );

  dg_query #(
    .SLOT_W    (SLOT_W),
    .LAST_SLOT (MAX_SLOTS - 1)
  ) u_query (
    .cls        (qry_class),
    .ctr_branch (qry_ctr_branch),
    .overlap    (qry_overlap),
    .slot       (slot_cnt),
    .unit_full  (unit_full),
    .ctr_flag   (ctr_flag),
    .verdict    (qry_verdict)
  );

endmodule

// File: rtl/dispatch_group_chk_sva.sv
module dispatch_group_chk_sva #(
  parameter int SLOT_W    = 3,
  parameter int LAST_SLOT = 4
) (
  input logic              clk,
  input logic              grp_rst_n,
  input logic [3:0]        qry_class,
  input logic [1:0]        qry_verdict,
  input logic              cmt_vld,
  input logic [3:0]        cmt_class,
  input logic              noop_vld,
  input logic              strobe_err,
  input logic [SLOT_W-1:0] slot_cnt
);

  // R12
  both_strobe_err_chk: assert property (@(posedge clk) disable iff (!grp_rst_n)
    (cmt_vld && noop_vld) |=> strobe_err);

  // R12
  both_strobe_ignored_chk: assert property (@(posedge clk) disable iff (!grp_rst_n)
    (cmt_vld && noop_vld) |=> $stable(slot_cnt));

  // R6
  branch_never_closed_chk: assert property (@(posedge clk) disable iff (!grp_rst_n)
    (qry_class == 4'd10) |-> (qry_verdict != 2'd1));

  // R11
  pseudo_quiet_chk: assert property (@(posedge clk) disable iff (!grp_rst_n)
    (qry_class == 4'd0) |-> (qry_verdict == 2'd0));

  // R11
  pseudo_commit_stable_chk: assert property (@(posedge clk) disable iff (!grp_rst_n)
    (cmt_vld && !noop_vld && cmt_class == 4'd0) |=> $stable(slot_cnt));

  // R7
  branch_commit_empties_chk: assert property (@(posedge clk) disable iff (!grp_rst_n)
    (cmt_vld && !noop_vld && cmt_class == 4'd10) |=> (slot_cnt == '0));

  // R10
  slot_bound_chk: assert property (@(posedge clk) disable iff (!grp_rst_n)
    slot_cnt <= SLOT_W'(LAST_SLOT));

  // R10
  noop_wrap_chk: assert property (@(posedge clk) disable iff (!grp_rst_n)
    (noop_vld && !cmt_vld && slot_cnt == SLOT_W'(LAST_SLOT)) |=> (slot_cnt == '0));

endmodule

bind dispatch_group_chk dispatch_group_chk_sva #(
  .SLOT_W    (SLOT_W),
  .LAST_SLOT (MAX_SLOTS - 1)
) u_sva (
  .clk         (clk),
  .grp_rst_n   (grp_rst_n),
  .qry_class   (qry_class),
  .qry_verdict (qry_verdict),
  .cmt_vld     (cmt_vld),
  .cmt_class   (cmt_class),
  .noop_vld    (noop_vld),
  .strobe_err  (strobe_err),
  .slot_cnt    (slot_cnt)
);

// File: tb/dispatch_group_chk_tb.sv
`timescale 1ns/1ps
module dispatch_group_chk_tb;

  localparam logic [3:0] PS = 4'd0, IN = 4'd1, IL = 4'd2, LD = 4'd3, ST = 4'd4,
                         FP = 4'd5, CR = 4'd6, SP = 4'd7, VA = 4'd8, VP = 4'd9,
                         BR = 4'd10;
  localparam logic [1:0] NONE = 2'd0, CLOSE = 2'd1, FILL = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] qry_class;
  logic       qry_ctr_branch;
  logic       qry_overlap;
  logic [1:0] qry_verdict;
  logic       cmt_vld;
  logic [3:0] cmt_class;
  logic       cmt_sets_ctr;
  logic       noop_vld;
  logic       strobe_err;

  int tests_run = 0;
  int tests_failed = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dispatch_group_chk u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .qry_class      (qry_class),
    .qry_ctr_branch (qry_ctr_branch),
    .qry_overlap    (qry_overlap),
    .qry_verdict    (qry_verdict),
    .cmt_vld        (cmt_vld),
    .cmt_class      (cmt_class),
    .cmt_sets_ctr   (cmt_sets_ctr),
    .noop_vld       (noop_vld),
    .strobe_err     (strobe_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      tests_failed = tests_failed + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    cmt_vld = 1'b0; noop_vld = 1'b0; cmt_sets_ctr = 1'b0; cmt_class = PS;
    qry_class = PS; qry_ctr_branch = 1'b0; qry_overlap = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic commit(input logic [3:0] c, input logic sets_ctr);
    @(negedge clk);
    cmt_vld = 1'b1; cmt_class = c; cmt_sets_ctr = sets_ctr;
    @(negedge clk);
    cmt_vld = 1'b0; cmt_sets_ctr = 1'b0;
  endtask

  task automatic noop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      noop_vld = 1'b1;
      @(negedge clk);
      noop_vld = 1'b0;
    end
  endtask

  task automatic check_q(input logic [3:0] c, input logic ctrb, input logic ovl,
                         input logic [1:0] exp, input string tag);
    qry_class = c; qry_ctr_branch = ctrb; qry_overlap = ovl;
    #2;
    tests_run++;
    if (qry_verdict !== exp) begin
      tests_failed++;
      $display("FAIL %s: class=%0d actual=%0d expected=%0d", tag, c, qry_verdict, exp);
    end
    qry_class = PS; qry_ctr_branch = 1'b0; qry_overlap = 1'b0;
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check_q(IN, 0, 0, NONE, "R1 int after reset");
    check_q(CR, 0, 0, NONE, "R1 cr after reset");
    check_q(VP, 0, 0, NONE, "R1 vperm after reset");
    check_q(BR, 0, 0, NONE, "R1 branch after reset");
    check_bit(strobe_err, 1'b0, "R1 err after reset");
  endtask

  task automatic t_int_quota();
    do_reset();
    commit(IL, 0);
    commit(IN, 0);
    check_q(IN, 0, 0, CLOSE, "R2 third int");
    check_q(LD, 0, 0, NONE,  "R2 load not blocked");
    check_q(FP, 0, 0, NONE,  "R2 fp not blocked");
  endtask

  task automatic t_ls_fp();
    do_reset();
    commit(LD, 0);
    commit(ST, 0);
    check_q(LD, 0, 0, CLOSE, "R3 third load/store");
    check_q(FP, 0, 0, NONE,  "R3 fp after ls quota");
    do_reset();
    commit(FP, 0);
    commit(FP, 0);
    check_q(FP, 0, 0, CLOSE, "R3 third fp");
    check_q(ST, 0, 0, NONE,  "R3 store after fp quota");
  endtask

  task automatic t_single();
    do_reset();
    commit(VA, 0);
    check_q(VA, 0, 0, CLOSE, "R4 second valu");
    check_q(VP, 0, 0, NONE,  "R4 vperm after valu");
    commit(VP, 0);
    check_q(VP, 0, 0, CLOSE, "R4 second vperm");
  endtask

  task automatic t_lead();
    do_reset();
    commit(IN, 0);
    check_q(CR, 0, 0, CLOSE, "R5 cr in slot 1");
    check_q(SP, 0, 0, CLOSE, "R5 spr in slot 1");
    check_q(IL, 0, 0, CLOSE, "R5 int-lead in slot 1");
    check_q(IN, 0, 0, NONE,  "R5 int in slot 1");
  endtask

  task automatic t_last();
    do_reset();
    commit(IN, 0); commit(LD, 0); commit(FP, 0); commit(VA, 0);
    check_q(ST, 0, 0, CLOSE, "R6 store in slot 5");
    check_q(IN, 0, 0, CLOSE, "R6 int in slot 5");
    check_q(BR, 0, 0, NONE,  "R6 branch in slot 5");
    commit(BR, 0);
    check_q(CR, 0, 0, NONE,  "R7 cr after branch closes");
    check_q(VA, 0, 0, NONE,  "R7 valu cleared");
  endtask

  task automatic t_branch_close();
    do_reset();
    commit(IN, 0);
    commit(BR, 0);
    check_q(IL, 0, 0, NONE, "R7 early branch empties group");
  endtask

  task automatic t_ctr();
    do_reset();
    commit(SP, 1);
    check_q(BR, 1, 0, FILL, "R8 ctr branch after ctr write");
    check_q(BR, 0, 0, NONE, "R8 plain branch after ctr write");
    do_reset();
    commit(SP, 0);
    check_q(BR, 1, 0, NONE, "R8 ctr branch without ctr write");
  endtask

  task automatic t_overlap();
    do_reset();
    check_q(LD, 0, 1, FILL, "R9 load with overlap");
    check_q(ST, 0, 1, NONE, "R9 store ignores overlap");
    check_q(IN, 0, 1, NONE, "R9 int ignores overlap");
    commit(LD, 0);
    commit(LD, 0);
    check_q(LD, 0, 1, CLOSE, "R9 quota beats overlap");
  endtask

  task automatic t_noop();
    do_reset();
    noop(1);
    check_q(CR, 0, 0, CLOSE, "R10 one filler moves slot");
    noop(3);
    check_q(IN, 0, 0, CLOSE, "R10 four fillers reach last slot");
    noop(1);
    check_q(CR, 0, 0, NONE, "R10 fifth filler empties group");
    commit(VA, 0);
    noop(4);
    check_q(VA, 0, 0, NONE, "R10 wrap clears flags");
  endtask

  task automatic t_pseudo();
    do_reset();
    check_q(PS, 1, 1, NONE, "R11 pseudo query");
    check_q(4'd13, 1, 1, NONE, "R11 unused code query");
    for (int i = 0; i < 5; i++) commit(PS, 1);
    check_q(CR, 0, 0, NONE, "R11 pseudo commits leave slot empty");
    check_q(BR, 1, 0, NONE, "R11 pseudo commit sets no ctr flag");
  endtask

  task automatic t_both();
    do_reset();
    @(negedge clk);
    cmt_vld = 1'b1; cmt_class = VA; noop_vld = 1'b1;
    @(negedge clk);
    cmt_vld = 1'b0; noop_vld = 1'b0;
    check_bit(strobe_err, 1'b1, "R12 error after double strobe");
    check_q(CR, 0, 0, NONE, "R12 slot unchanged");
    check_q(VA, 0, 0, NONE, "R12 commit ignored");
    @(negedge clk);
    check_bit(strobe_err, 1'b0, "R12 error clears");
  endtask

  initial begin
    t_reset();
    t_int_quota();
    t_ls_fp();
    t_single();
    t_lead();
    t_last();
    t_branch_close();
    t_ctr();
    t_overlap();
    t_noop();
    t_pseudo();
    t_both();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule